// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sits between a CPU load/store unit and the memory system. Each cycle it may accept one request made of a 32-bit virtual address, a read/write flag and an access size. It answers one cycle later with a routing decision. The decision names exactly one target (main RAM, boot ROM, scratchpad, the I/O register window, the cache-control register, the instruction cache, or an unmapped hole), the offset to present to that target, and whether the target should accept a write. When the access is refused, the response instead raises a bus error or an address error.

The decode proceeds in a fixed order:

1. The alignment check on the size and the low address bits comes first.
2. The top three address bits then pick a segment. Two segments are cached views of physical memory, one is an uncached view, three are refused user space, and the top two hold only the cache-control register.
3. Inside a cached view, two further checks apply. With the isolate-cache status bit set, writes are diverted to the instruction cache. A 1 KB physical window is carved out as scratchpad.
4. The physical address is the low 29 bits of the virtual address. It is matched against the RAM, boot ROM and I/O windows.

Reads that hit a refused or unmapped area get an all-ones fill word. The address of the most recent misaligned request is held in a register for the exception handler.

Top module: `vaddr_seg_decoder`

## Requirements
- R1: Size encoding is 0 byte, 1 halfword, 2 word, 3 treated as word. A halfword with address bit 0 set, or a word with either of bits 1:0 set, raises `rsp_addr_err` with no target selected and offset 0. It sets `rsp_addr_err_store` equal to the write flag and loads `bad_vaddr` with the address; `bad_vaddr` is unchanged by other requests.
- R2: Aligned requests whose address bits 31:29 are 1, 2 or 3 raise `rsp_bus_err` with no target selected.
- R3: In segments 6 and 7, only the exact address 0xFFFE0130 is accepted; it selects the cache-control target with offset 0. Every other address there raises `rsp_bus_err`.
- R4: A write in segment 0 or 4 while `isolate_cache` is high selects the instruction-cache target, with the 29-bit physical address as offset. Reads, and any access in segment 5, are not diverted.
- R5: In segment 0 or 4, a physical address with bits 28:10 equal to 0x7E000 selects the scratchpad with offset equal to physical bits 9:0. In segment 5 the same address is an unmapped hole.
- R6: A physical address below 0x800000 selects RAM with offset equal to the physical address modulo 0x200000.
- R7: A physical address in 0x1FC00000 to 0x1FC7FFFF selects the boot ROM with offset physical minus 0x1FC00000. Writes there have `rsp_wr_en` low.
- R8: A physical address in 0x1F801000 to 0x1F802FFF selects the I/O window with offset physical minus 0x1F801000.
- R9: Any other physical address selects the hole target with the physical address as offset. A read of a hole, or a read that raises a bus error, returns `rsp_fill_data` = 0xFFFFFFFF; every other response returns 0.
- R10: `rsp_valid` follows `req_valid` by one clock. `rsp_sel` bit 0 is RAM, 1 boot ROM, 2 scratchpad, 3 I/O, 4 cache-control, 5 instruction cache, 6 hole. Exactly one bit is set on a response without error. After reset, `rsp_valid` is 0 and `bad_vaddr` is 0.
- R11: `rsp_wr_en` is high only for a write that selects RAM, scratchpad, I/O, cache-control or instruction cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Access size code |
| isolate_cache | input | 1 | Isolate-cache status bit |
| rsp_valid | output | 1 | Response present |
| rsp_sel | output | 7 | One-hot target select |
| rsp_offset | output | 29 | Offset within the selected target |
| rsp_bus_err | output | 1 | Bus error |
| rsp_addr_err | output | 1 | Alignment error |
| rsp_addr_err_store | output | 1 | Alignment error came from a store |
| rsp_wr_en | output | 1 | Target should accept write data |
| rsp_fill_data | output | 32 | All-ones fill for refused reads |
| bad_vaddr | output | 32 | Last misaligned address |

## Verification
The sweep walks each physical test point through all eight segments, all three sizes, three low-bit offsets and both isolate settings. The points are chosen at window edges: the last RAM mirror word, the first and last scratchpad words, the word after the scratchpad, the I/O ends and the ROM ends.

The sweep targets several ways a design could go wrong:
- Decoding the scratchpad in the uncached segment would select scratchpad where a hole is expected.
- Diverting isolated reads would send loads to the instruction cache.
- Testing alignment after segment decode would report a bus error for misaligned accesses in refused segments, where an address error is expected.
- Matching the cache-control address on fewer bits would accept its byte neighbours.

Extra checks confirm that a good request leaves `bad_vaddr` alone and that ROM writes carry no write enable.

// File: rtl/vsd_pkg.sv
// Package: shared encodings for the virtual address segment decoder.
// Assumes a 32-bit virtual address with a 29-bit physical part.
package vsd_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        SEG_CACHED   = 3'd0,
        SEG_UNCACHED = 3'd1,
        SEG_FAULT    = 3'd2,
        SEG_CCTRL    = 3'd3,
        SEG_ISOLATE  = 3'd4
    } seg_class_e;

    localparam int VA_W      = 32;
    localparam int PA_W      = 29;
    localparam int TGT_COUNT = 7;
    localparam int TGT_IDX_W = $clog2(TGT_COUNT);

    localparam logic [TGT_IDX_W-1:0] TGT_RAM     = 3'd0;
    localparam logic [TGT_IDX_W-1:0] TGT_ROM     = 3'd1;
    localparam logic [TGT_IDX_W-1:0] TGT_SCRATCH = 3'd2;
    localparam logic [TGT_IDX_W-1:0] TGT_IO      = 3'd3;
    localparam logic [TGT_IDX_W-1:0] TGT_CCTRL   = 3'd4;
    localparam logic [TGT_IDX_W-1:0] TGT_ICACHE  = 3'd5;
    localparam logic [TGT_IDX_W-1:0] TGT_HOLE    = 3'd6;

    // Targets that take write data.
    localparam logic [TGT_COUNT-1:0] TGT_WRITABLE = 7'b011_1101;

endpackage

// File: rtl/vsd_align_check.sv
// Module: alignment checker.
// Flags a halfword with an odd address and a word (or reserved size) whose
// address is not a multiple of four. Byte accesses are never misaligned.
module vsd_align_check
    import vsd_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic       misaligned
);

    // Compare low address bits against the alignment the size needs.
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr_lo[0];
            default: misaligned = |addr_lo;
        endcase
    end

endmodule

// File: rtl/vsd_seg_classify.sv
// Module: segment classifier.
// Looks at virtual bits 31:29 and sorts the request into a cached window,
// the uncached window, a refused area, the cache-control register, or an
// isolated-cache write. Assumes CCTRL_ADDR lies in segment 6 or 7.
module vsd_seg_classify
    import vsd_pkg::*;
#(
    parameter logic [VA_W-1:0] CCTRL_ADDR = 32'hFFFE_0130
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic            write,
    input  logic            isolate,
    output seg_class_e      cls
);

    localparam int SEG_LSB = PA_W;

    // Segment number picks the class; two segments hold one special register.
    always_comb begin
        unique case (vaddr[VA_W-1:SEG_LSB])
            3'd0, 3'd4: cls = (write && isolate) ? SEG_ISOLATE : SEG_CACHED;
            3'd5:       cls = SEG_UNCACHED;
            3'd6, 3'd7: cls = (vaddr == CCTRL_ADDR) ? SEG_CCTRL : SEG_FAULT;
            default:    cls = SEG_FAULT;
        endcase
    end

endmodule

// File: rtl/vsd_phys_map.sv
// Module: physical window map.
// Maps a 29-bit physical address to a target index and offset. The
// scratchpad is matched only when the access comes through a cached window.
// Assumes ROM and scratchpad bases are aligned to their sizes.
module vsd_phys_map
    import vsd_pkg::*;
#(
    parameter logic [PA_W-1:0] RAM_LIMIT  = 29'h0080_0000,
    parameter int              RAM_BITS   = 21,
    parameter logic [PA_W-1:0] ROM_BASE   = 29'h1FC0_0000,
    parameter int              ROM_BITS   = 19,
    parameter logic [PA_W-1:0] SCR_BASE   = 29'h1F80_0000,
    parameter int              SCR_BITS   = 10,
    parameter logic [PA_W-1:0] IO_BASE    = 29'h1F80_1000,
    parameter logic [PA_W-1:0] IO_SIZE    = 29'h0000_2000
) (
    input  logic [PA_W-1:0]      paddr,
    input  logic                 cached,
    output logic [TGT_IDX_W-1:0] tgt,
    output logic [PA_W-1:0]      offset
);

    localparam logic [PA_W-1:0] RAM_MASK = (29'd1 << RAM_BITS) - 29'd1;
    localparam logic [PA_W-1:0] ROM_MASK = (29'd1 << ROM_BITS) - 29'd1;
    localparam logic [PA_W-1:0] SCR_MASK = (29'd1 << SCR_BITS) - 29'd1;
    localparam logic [PA_W-1:0] ROM_END  = ROM_BASE + (29'd1 << ROM_BITS);
    localparam logic [PA_W-1:0] IO_END   = IO_BASE + IO_SIZE;

    logic scr_hit;
    logic ram_hit;
    logic rom_hit;
    logic io_hit;

    // Window hit terms.
    always_comb begin
        scr_hit = cached && (paddr[PA_W-1:SCR_BITS] == SCR_BASE[PA_W-1:SCR_BITS]);
        ram_hit = paddr < RAM_LIMIT;
        rom_hit = (paddr >= ROM_BASE) && (paddr < ROM_END);
        io_hit  = (paddr >= IO_BASE) && (paddr < IO_END);
    end

    // Priority select of target and offset; scratchpad first.
    always_comb begin
        if (scr_hit) begin
            tgt    = TGT_SCRATCH;
            offset = paddr & SCR_MASK;
        end else if (ram_hit) begin
            tgt    = TGT_RAM;
            offset = paddr & RAM_MASK;
        end else if (rom_hit) begin
            tgt    = TGT_ROM;
            offset = paddr & ROM_MASK;
        end else if (io_hit) begin
            tgt    = TGT_IO;
            offset = paddr - IO_BASE;
        end else begin
            tgt    = TGT_HOLE;
            offset = paddr;
        end
    end

endmodule

// File: rtl/vaddr_seg_decoder.sv
// Module: virtual address segment decoder (top).
// One request per cycle in, one registered response a cycle later. The
// alignment check has priority over segment decode. Errors select no target.
// The last misaligned address is held in bad_vaddr.
module vaddr_seg_decoder
    import vsd_pkg::*;
#(
    parameter logic [VA_W-1:0] CCTRL_ADDR = 32'hFFFE_0130,
    parameter logic [PA_W-1:0] RAM_LIMIT  = 29'h0080_0000,
    parameter int              RAM_BITS   = 21,
    parameter logic [PA_W-1:0] ROM_BASE   = 29'h1FC0_0000,
    parameter int              ROM_BITS   = 19,
    parameter logic [PA_W-1:0] SCR_BASE   = 29'h1F80_0000,
    parameter int              SCR_BITS   = 10,
    parameter logic [PA_W-1:0] IO_BASE    = 29'h1F80_1000,
    parameter logic [PA_W-1:0] IO_SIZE    = 29'h0000_2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_addr,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic                 isolate_cache,
    output logic                 rsp_valid,
    output logic [TGT_COUNT-1:0] rsp_sel,
    output logic [PA_W-1:0]      rsp_offset,
    output logic                 rsp_bus_err,
    output logic                 rsp_addr_err,
    output logic                 rsp_addr_err_store,
    output logic                 rsp_wr_en,
    output logic [VA_W-1:0]      rsp_fill_data,
    output logic [VA_W-1:0]      bad_vaddr
);

    logic [PA_W-1:0]      paddr;
    logic                 misaligned;
    seg_class_e           cls;
    logic [TGT_IDX_W-1:0] map_tgt;
    logic [PA_W-1:0]      map_off;

    logic [TGT_COUNT-1:0] n_sel;
    logic [PA_W-1:0]      n_off;
    logic                 n_be;
    logic                 n_ae;
    logic                 n_we;
    logic [VA_W-1:0]      n_fill;

    assign paddr = req_addr[PA_W-1:0];

    vsd_align_check u_align (
        .size       (req_size),
        .addr_lo    (req_addr[1:0]),
        .misaligned (misaligned)
    );

    vsd_seg_classify #(.CCTRL_ADDR(CCTRL_ADDR)) u_seg (
        .vaddr   (req_addr),
        .write   (req_write),
        .isolate (isolate_cache),
        .cls     (cls)
    );

    vsd_phys_map #(
        .RAM_LIMIT (RAM_LIMIT),
        .RAM_BITS  (RAM_BITS),
        .ROM_BASE  (ROM_BASE),
        .ROM_BITS  (ROM_BITS),
        .SCR_BASE  (SCR_BASE),
        .SCR_BITS  (SCR_BITS),
        .IO_BASE   (IO_BASE),
        .IO_SIZE   (IO_SIZE)
    ) u_map (
        .paddr  (paddr),
        .cached (cls == SEG_CACHED),
        .tgt    (map_tgt),
        .offset (map_off)
    );

    // Combine alignment, segment class and window map into one decision.
    always_comb begin
        n_sel = '0;
        n_off = '0;
        n_be  = 1'b0;
        n_ae  = 1'b0;
        if (misaligned) begin
            n_ae = 1'b1;
        end else begin
            unique case (cls)
                SEG_FAULT:   n_be = 1'b1;
                SEG_CCTRL:   n_sel[TGT_CCTRL] = 1'b1;
                SEG_ISOLATE: begin
                    n_sel[TGT_ICACHE] = 1'b1;
                    n_off             = paddr;
                end
                default: begin
                    n_sel[map_tgt] = 1'b1;
                    n_off          = map_off;
                end
            endcase
        end
    end

    // Write enable and fill word per lane-independent rules.
    always_comb begin
        n_we   = req_write && |(n_sel & TGT_WRITABLE);
        n_fill = (!req_write && (n_be || n_sel[TGT_HOLE])) ? '1 : '0;
    end

    // Response register: valid tracks request, fields load on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid          <= 1'b0;
            rsp_sel            <= '0;
            rsp_offset         <= '0;
            rsp_bus_err        <= 1'b0;
            rsp_addr_err       <= 1'b0;
            rsp_addr_err_store <= 1'b0;
            rsp_wr_en          <= 1'b0;
            rsp_fill_data      <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_sel            <= n_sel;
                rsp_offset         <= n_off;
                rsp_bus_err        <= n_be;
                rsp_addr_err       <= n_ae;
                rsp_addr_err_store <= n_ae && req_write;
                rsp_wr_en          <= n_we;
                rsp_fill_data      <= n_fill;
            end
        end
    end

    // Faulting-address register: loads only on a misaligned request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_vaddr <= '0;
        end else if (req_valid && misaligned) begin
            bad_vaddr <= req_addr;
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_bus_err && !rsp_addr_err |-> $countones(rsp_sel) == 1); // R10
    AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_bus_err || rsp_addr_err) |-> rsp_sel == '0); // R2
    AST_BAD_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_addr_err |-> bad_vaddr == $past(req_addr)); // R1
    AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_sel[TGT_ROM] |-> !rsp_wr_en); // R7
    AST_FILL_ONLY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fill_data != '0 |-> rsp_bus_err || rsp_sel[TGT_HOLE]); // R9

endmodule

// File: tb/tb_vaddr_seg_decoder.sv
// Bench: sweeps segments, edge physical addresses, sizes, low bits, write
// and isolate settings; expected values are computed from the requirements.
module tb_vaddr_seg_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_write;
    logic [1:0]  req_size;
    logic        isolate_cache;
    logic        rsp_valid;
    logic [6:0]  rsp_sel;
    logic [28:0] rsp_offset;
    logic        rsp_bus_err;
    logic        rsp_addr_err;
    logic        rsp_addr_err_store;
    logic        rsp_wr_en;
    logic [31:0] rsp_fill_data;
    logic [31:0] bad_vaddr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    vaddr_seg_decoder dut (
        .clk                (clk),
        .rst_n              (rst_n),
        .req_valid          (req_valid),
        .req_addr           (req_addr),
        .req_write          (req_write),
        .req_size           (req_size),
        .isolate_cache      (isolate_cache),
        .rsp_valid          (rsp_valid),
        .rsp_sel            (rsp_sel),
        .rsp_offset         (rsp_offset),
        .rsp_bus_err        (rsp_bus_err),
        .rsp_addr_err       (rsp_addr_err),
        .rsp_addr_err_store (rsp_addr_err_store),
        .rsp_wr_en          (rsp_wr_en),
        .rsp_fill_data      (rsp_fill_data),
        .bad_vaddr          (bad_vaddr)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference from the requirement text.
    task automatic model(input logic [31:0] a, input logic w, input logic [1:0] sz,
                         input logic iso, output logic [6:0] s, output logic [28:0] off,
                         output logic be, output logic ae, output logic st,
                         output logic we, output logic [31:0] fill, output string tag);
        logic [2:0]  seg;
        logic [28:0] p;
        seg = a[31:29];
        p   = a[28:0];
        s = 0; off = 0; be = 0; ae = 0; st = 0;
        if ((sz == 2'd1 && a[0]) || (sz >= 2'd2 && a[1:0] != 0)) begin
            ae = 1; st = w; tag = "R1";
        end else if (seg >= 1 && seg <= 3) begin
            be = 1; tag = "R2";
        end else if (seg >= 6) begin
            tag = "R3";
            if (a == 32'hFFFE_0130) s = 7'h10;
            else be = 1;
        end else if (seg != 5 && w && iso) begin
            s = 7'h20; off = p; tag = "R4";
        end else if (seg != 5 && p >= 29'h1F80_0000 && p < 29'h1F80_0400) begin
            s = 7'h04; off = p - 29'h1F80_0000; tag = "R5";
        end else if (p < 29'h0080_0000) begin
            s = 7'h01; off = p % 29'h0020_0000; tag = "R6";
        end else if (p >= 29'h1FC0_0000 && p < 29'h1FC8_0000) begin
            s = 7'h02; off = p - 29'h1FC0_0000; tag = "R7";
        end else if (p >= 29'h1F80_1000 && p < 29'h1F80_3000) begin
            s = 7'h08; off = p - 29'h1F80_1000; tag = "R8";
        end else begin
            s = 7'h40; off = p; tag = "R9";
        end
        we   = w && (s == 7'h01 || s == 7'h04 || s == 7'h08 || s == 7'h10 || s == 7'h20);
        fill = (!w && (be || s == 7'h40)) ? 32'hFFFF_FFFF : 32'h0;
    endtask

    // Drive at a falling edge, sample at the next falling edge.
    task automatic run_one(input logic [31:0] a, input logic w, input logic [1:0] sz,
                           input logic iso, input string extra);
        logic [6:0]  s;
        logic [28:0] off;
        logic        be, ae, st, we;
        logic [31:0] fill;
        string       tag;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = w; req_size = sz; isolate_cache = iso;
        @(negedge clk);
        req_valid = 0;
        model(a, w, sz, iso, s, off, be, ae, st, we, fill, tag);
        chk({rsp_valid, rsp_sel, rsp_offset, rsp_bus_err, rsp_addr_err,
             rsp_addr_err_store, rsp_wr_en, rsp_fill_data} ==
            {1'b1, s, off, be, ae, st, we, fill},
            {tag, extra, " R10 R11"},
            {rsp_valid, rsp_sel, rsp_offset, rsp_bus_err, rsp_addr_err,
             rsp_addr_err_store, rsp_wr_en, rsp_fill_data},
            {1'b1, s, off, be, ae, st, we, fill});
    endtask

    logic [28:0] pts [20] = '{29'h0, 29'h4, 29'h1F_FFFC, 29'h20_0000, 29'h7F_FFFC,
        29'h80_0000, 29'h1F7F_FFFC, 29'h1F80_0000, 29'h1F80_03FC, 29'h1F80_0400,
        29'h1F80_0FFC, 29'h1F80_1000, 29'h1F80_2FFC, 29'h1F80_3000, 29'h1FBF_FFFC,
        29'h1FC0_0000, 29'h1FC7_FFFC, 29'h1FC8_0000, 29'h1FFE_0130, 29'h1FFF_FFFC};

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_addr = 0; req_write = 0; req_size = 0;
        isolate_cache = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk({rsp_valid, bad_vaddr} == 33'h0, "R10 reset", {rsp_valid, bad_vaddr}, 33'h0);

        // Main sweep.
        for (int seg = 0; seg < 8; seg++)
            for (int i = 0; i < 20; i++)
                for (int lo = 0; lo < 3; lo++)
                    for (int sz = 0; sz < 3; sz++)
                        for (int wi = 0; wi < 4; wi++)
                            run_one({seg[2:0], pts[i]} + lo, wi[0], sz[1:0], wi[1], " sweep");

        // R1: bad address loaded, then held over a good request.
        run_one(32'hA000_0102, 1'b1, 2'd2, 1'b0, " misaligned store");
        chk(bad_vaddr == 32'hA000_0102, "R1 load", bad_vaddr, 32'hA000_0102);
        run_one(32'hA000_0200, 1'b0, 2'd2, 1'b0, " good");
        chk(bad_vaddr == 32'hA000_0102, "R1 hold", bad_vaddr, 32'hA000_0102);
        // R1: reserved size behaves as word
        run_one(32'h0000_0002, 1'b0, 2'd3, 1'b0, " size3");
        // R3: neighbour of the control register
        run_one(32'hFFFE_0134, 1'b0, 2'd2, 1'b0, " neighbour");
        // R4 / R5: uncached window neither diverts nor maps scratchpad
        run_one(32'hBF80_0010, 1'b1, 2'd2, 1'b1, " uncached R4 R5");
        // R7: ROM write gives no enable
        run_one(32'hBFC0_0000, 1'b1, 2'd2, 1'b0, " rom write");
        chk(rsp_wr_en == 1'b0, "R7 rom write ignored", rsp_wr_en, 1'b0);
        // R11: RAM write enabled
        run_one(32'h8000_0040, 1'b1, 2'd0, 1'b0, " ram write");
        chk(rsp_wr_en == 1'b1, "R11 ram write", rsp_wr_en, 1'b1);
        // R10: no request, no response
        @(negedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 idle", rsp_valid, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule